// File: doc/BRIEF.md
# Disk Rotational Position Tracker and Word Scheduler

This block keeps the angular position of a head-per-track disk as a word counter. A prescaler turns the system clock into one word time per programmable number of cycles. A position counter advances once per word time and wraps after the last word of the track. From that position the block derives a wide index window, which stands in for the photocell, and a compare flag that is true when a given disk address is under the heads.

The transfer engine asks for a transfer by pulsing a request with the target disk address. The scheduler state machine has three states. IDLE waits for a request. WAIT counts down the forward rotational distance to the target word. STREAM issues one word strobe each time the position advances. The transitions are:

- IDLE→WAIT on an accepted request.
- WAIT→STREAM when the countdown reaches zero and the first strobe goes out.
- WAIT→IDLE when that first strobe goes out with burst mode set.
- STREAM→IDLE when the engine signals completion, or when burst mode is raised.

While the machine is in WAIT or STREAM, further requests have no effect.

Top module: `rot_tracker`

## Requirements
- R1: While reset is held, the position is 0, the index flag is 1, the word strobe is 0 and busy is 0. Reset sets the inter-word time to 1 clock cycle.
- R2: With inter-word time T, the position advances by one every T cycles and wraps from WORDS-1 to 0. The word tick is high in exactly the last cycle of each word time. A write of a nonzero time restarts the phase, so the position first advances T cycles after the write edge.
- R3: A write of a nonzero inter-word time takes effect at once. A write of zero is rejected: the previous time and the phase are kept unchanged.
- R4: The index flag is 1 exactly when the position is in the range 0 to IDX_WIN-1 (0 to 5 by default).
- R5: The address-match output is 1 exactly when the low log2(WORDS) bits of the compare address equal the position. The higher address bits are ignored.
- R6: A request taken in IDLE captures the low log2(WORDS) bits of the request address as the target. The start delay is (target − next position) mod WORDS word times. No strobe is issued before the target word, and the first strobe is issued in the first cycle in which the position equals the target. Busy is high from the cycle after the request.
- R7: In STREAM, exactly one word strobe is issued in each cycle that immediately follows an advance of the position, and none in any other cycle.
- R8: Completion asserted in STREAM suppresses a strobe in that cycle and returns the machine to IDLE. Busy is low in the next cycle, and no further strobes follow.
- R9: If burst mode is high when the first strobe is issued, that is the only strobe and the machine returns to IDLE. Burst mode raised during STREAM also ends the stream without a strobe.
- R10: A request made while busy is ignored. The target and the strobe pattern of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iw_wr | input | 1 | Write strobe for the inter-word time |
| iw_time | input | TIME_W | New inter-word time in clock cycles; zero is rejected |
| cmp_addr | input | ADDR_W | Disk address compared against the position |
| req_start | input | 1 | Transfer request pulse |
| req_addr | input | ADDR_W | Disk address of the first word of the transfer |
| xfer_done | input | 1 | Transfer engine reports the transfer complete |
| burst_mode | input | 1 | Engine moves the remaining words itself after the first strobe |
| position | output | log2(WORDS) | Current angular word position |
| word_tick | output | 1 | High in the last cycle of each word time |
| index_flag | output | 1 | Photocell index window flag |
| addr_match | output | 1 | Compare address equals the position |
| word_strobe | output | 1 | One-cycle strobe per word to transfer |
| busy | output | 1 | Scheduler is in WAIT or STREAM |

## Verification
A wrong prescaler count or a wrong time register shows at the position port within one word time. It then grows into a drift that the position sweep catches on the next sample. A wrong position shifts the index window and the match flag in the same cycle. A countdown that is out of step with the position puts the first strobe on a cycle in which the position differs from the target, so the error is visible at the first strobe, at most one revolution after the request. A stuck or wrong state shows as a missing or extra strobe within one word time, or as busy not dropping in the cycle after completion or after a burst strobe.

// File: rtl/rot_pkg.sv
package rot_pkg;

    typedef enum logic [1:0] {
        SCH_IDLE   = 2'd0,
        SCH_WAIT   = 2'd1,
        SCH_STREAM = 2'd2
    } sch_state_t;

endpackage

// File: rtl/rot_iw_prescaler.sv
// Inter-word time register and cycle prescaler: one tick per word time.
module rot_iw_prescaler #(
    parameter int TIME_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iw_wr,
    input  logic [TIME_W-1:0] iw_time,
    output logic              tick
);

    logic [TIME_W-1:0] time_q;
    logic [TIME_W-1:0] cnt_q;
    logic              accept;

    // A zero time would stall rotation, so such a write is dropped.
    assign accept = iw_wr && (iw_time != '0);
    assign tick   = (cnt_q >= time_q - TIME_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= TIME_W'(1);
            cnt_q  <= '0;
        end else if (accept) begin
            time_q <= iw_time;
            cnt_q  <= '0;
        end else if (tick) begin
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + TIME_W'(1);
        end
    end

    p_time_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        time_q != '0);

    p_zero_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_wr && iw_time == '0) |=> (time_q == $past(time_q)));

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !accept && time_q > TIME_W'(1)) |=> !tick);

endmodule

// File: rtl/rot_position.sv
// Angular position counter, index window and address compare.
module rot_position #(
    parameter int WORDS   = 2048,
    parameter int IDX_WIN = 6,
    parameter int POS_W   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [POS_W-1:0] cmp_low,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_nxt,
    output logic             index_flag,
    output logic             addr_match
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORDS - 1);
    localparam logic [POS_W-1:0] IDX_END  = POS_W'(IDX_WIN);

    logic [POS_W-1:0] pos_q;

    always_comb begin
        if (!tick) begin
            pos_nxt = pos_q;
        end else if (pos_q == LAST_POS) begin
            pos_nxt = '0;
        end else begin
            pos_nxt = pos_q + POS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_nxt;
        end
    end

    assign pos        = pos_q;
    assign index_flag = (pos_q < IDX_END);
    assign addr_match = (cmp_low == pos_q);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pos_q == LAST_POS) |=> (pos_q == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pos_q));

    p_index_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pos_q == LAST_POS) |=> index_flag);

endmodule

// File: rtl/rot_scheduler.sv
// Start-delay countdown and per-word strobe state machine.
module rot_scheduler
    import rot_pkg::*;
#(
    parameter int WORDS = 2048,
    parameter int POS_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] pos_nxt,
    input  logic             req_start,
    input  logic [POS_W-1:0] req_tgt,
    input  logic             xfer_done,
    input  logic             burst_mode,
    output logic             word_strobe,
    output logic             busy
);

    localparam logic [POS_W:0] TRACK_LEN = (POS_W + 1)'(WORDS);

    sch_state_t       state_q, state_d;
    logic [POS_W-1:0] remain_q;
    logic [POS_W-1:0] target_q;
    logic             adv_q;
    logic [POS_W:0]   diff_w;
    logic [POS_W-1:0] delay_w;
    logic             at_target;

    // Forward distance measured from the position valid after this edge,
    // so a word advance in the request cycle is already accounted for.
    always_comb begin
        diff_w  = {1'b0, req_tgt} - {1'b0, pos_nxt};
        delay_w = diff_w[POS_W] ? POS_W'(diff_w + TRACK_LEN) : diff_w[POS_W-1:0];
    end

    assign at_target = (remain_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_IDLE: begin
                if (req_start) state_d = SCH_WAIT;
            end
            SCH_WAIT: begin
                if (at_target) state_d = burst_mode ? SCH_IDLE : SCH_STREAM;
            end
            SCH_STREAM: begin
                if (xfer_done || burst_mode) state_d = SCH_IDLE;
            end
            default: state_d = SCH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        word_strobe = 1'b0;
        busy        = 1'b0;
        unique case (state_q)
            SCH_IDLE: begin
                word_strobe = 1'b0;
                busy        = 1'b0;
            end
            SCH_WAIT: begin
                word_strobe = at_target;
                busy        = 1'b1;
            end
            SCH_STREAM: begin
                word_strobe = adv_q && !xfer_done && !burst_mode;
                busy        = 1'b1;
            end
            default: begin
                word_strobe = 1'b0;
                busy        = 1'b0;
            end
        endcase
    end

    // Countdown, target capture and advance marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            target_q <= '0;
            adv_q    <= 1'b0;
        end else begin
            adv_q <= tick;
            if (state_q == SCH_IDLE && req_start) begin
                remain_q <= delay_w;
                target_q <= req_tgt;
            end else if (state_q == SCH_WAIT && tick && !at_target) begin
                remain_q <= remain_q - POS_W'(1);
            end
        end
    end

    p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCH_WAIT && at_target) |-> (pos == target_q));

    p_stream_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCH_STREAM && word_strobe) |-> (pos != $past(pos)));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCH_STREAM && xfer_done) |=> (state_q == SCH_IDLE));

    p_burst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && burst_mode) |=> (state_q == SCH_IDLE));

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SCH_IDLE) |=> $stable(target_q));

endmodule

// File: rtl/rot_tracker.sv
// Top: rotational position tracker with transfer start scheduling.
module rot_tracker #(
    parameter int WORDS   = 2048,
    parameter int IDX_WIN = 6,
    parameter int TIME_W  = 24,
    parameter int ADDR_W  = 12,
    localparam int POS_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iw_wr,
    input  logic [TIME_W-1:0] iw_time,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              xfer_done,
    input  logic              burst_mode,
    output logic [POS_W-1:0]  position,
    output logic              word_tick,
    output logic              index_flag,
    output logic              addr_match,
    output logic              word_strobe,
    output logic              busy
);

    logic             tick;
    logic [POS_W-1:0] pos_nxt;
    logic             unused_hi;

    // Bits above the track word index select track and disk; not used here.
    assign unused_hi = ^{cmp_addr[ADDR_W-1:POS_W], req_addr[ADDR_W-1:POS_W]};

    rot_iw_prescaler #(
        .TIME_W (TIME_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .iw_wr   (iw_wr),
        .iw_time (iw_time),
        .tick    (tick)
    );

    rot_position #(
        .WORDS   (WORDS),
        .IDX_WIN (IDX_WIN),
        .POS_W   (POS_W)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmp_low    (cmp_addr[POS_W-1:0]),
        .pos        (position),
        .pos_nxt    (pos_nxt),
        .index_flag (index_flag),
        .addr_match (addr_match)
    );

    rot_scheduler #(
        .WORDS (WORDS),
        .POS_W (POS_W)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .pos         (position),
        .pos_nxt     (pos_nxt),
        .req_start   (req_start),
        .req_tgt     (req_addr[POS_W-1:0]),
        .xfer_done   (xfer_done),
        .burst_mode  (burst_mode),
        .word_strobe (word_strobe),
        .busy        (busy)
    );

    assign word_tick = tick;

    p_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_strobe |-> busy);

endmodule

// File: tb/sim_rot_tracker.sv
module sim_rot_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int W   = 32;
    localparam int TW  = 4;
    localparam int AW  = 12;
    localparam int IDX = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iw_wr = 1'b0;
    logic [TW-1:0] iw_time = '0;
    logic [AW-1:0] cmp_addr = '0;
    logic          req_start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          xfer_done = 1'b0;
    logic          burst_mode = 1'b0;
    logic [4:0]    position;
    logic          word_tick, index_flag, addr_match, word_strobe, busy;

    int checks = 0;
    int fails  = 0;

    rot_tracker #(.WORDS(W), .IDX_WIN(IDX), .TIME_W(TW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .iw_wr(iw_wr), .iw_time(iw_time),
        .cmp_addr(cmp_addr), .req_start(req_start), .req_addr(req_addr),
        .xfer_done(xfer_done), .burst_mode(burst_mode), .position(position),
        .word_tick(word_tick), .index_flag(index_flag), .addr_match(addr_match),
        .word_strobe(word_strobe), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Position sweep over more than one revolution with time t.
    // zero_at >= 0 issues a rejected zero write at that sample.
    task automatic sweep(input int t, input int zero_at);
        int base;
        int expp;
        string tag;
        iw_wr = 1'b1;
        iw_time = TW'(t);
        step;
        iw_wr = 1'b0;
        base = int'(position);
        for (int k = 0; k < W * t + 3; k++) begin
            expp = (base + k / t) % W;
            tag = (zero_at >= 0 && k > zero_at) ? "R3 position after zero write"
                                                : "R2 R3 position";
            chk(int'(position) == expp, tag, int'(position), expp);
            chk(word_tick == ((k % t) == t - 1), "R2 word_tick", int'(word_tick),
                int'((k % t) == t - 1));
            chk(index_flag == (expp < IDX), "R4 index_flag", int'(index_flag),
                int'(expp < IDX));
            chk(addr_match == (int'(cmp_addr[4:0]) == expp), "R5 addr_match",
                int'(addr_match), int'(int'(cmp_addr[4:0]) == expp));
            cmp_addr = AW'((k * 7 + 3) % W) | ((k % 2 == 1) ? AW'(12'hFE0) : AW'(0));
            if (k == zero_at) begin
                iw_wr = 1'b1;
                iw_time = '0;
            end else begin
                iw_wr = 1'b0;
            end
            step;
        end
        iw_wr = 1'b0;
    endtask

    // One scheduled transfer to target tgt.
    task automatic sched(input int tgt, input bit burst, input int nwords, input int t);
        int low;
        int prev;
        bit hit;
        low = tgt % W;
        prev = 0;
        req_addr = AW'(tgt) | AW'(12'hAC0);
        burst_mode = burst;
        req_start = 1'b1;
        step;
        req_start = 1'b0;
        hit = 1'b0;
        for (int k = 0; k < W * (t + 1) + 10 && !hit; k++) begin
            chk(busy == 1'b1, "R6 busy while waiting", int'(busy), 1);
            if (int'(position) == low) begin
                chk(word_strobe == 1'b1, "R6 first strobe at target", int'(word_strobe), 1);
                hit = 1'b1;
                prev = int'(position);
            end else begin
                chk(word_strobe == 1'b0, "R6 no strobe before target", int'(word_strobe), 0);
                step;
            end
        end
        if (!hit) chk(1'b0, "R6 target never reached", int'(position), low);
        if (burst) begin
            step;
            chk(busy == 1'b0, "R9 idle after burst strobe", int'(busy), 0);
            for (int i = 0; i < 2 * t + 4; i++) begin
                chk(word_strobe == 1'b0, "R9 single strobe in burst", int'(word_strobe), 0);
                step;
            end
            burst_mode = 1'b0;
        end else begin
            step;
            for (int i = 0; i < nwords; i++) begin
                chk(word_strobe == (int'(position) != prev), "R7 R10 strobe per word",
                    int'(word_strobe), int'(int'(position) != prev));
                if (i == 3) begin
                    req_addr = AW'((low + 9) % W);
                    req_start = 1'b1;
                end else begin
                    req_start = 1'b0;
                end
                prev = int'(position);
                step;
            end
            req_start = 1'b0;
            xfer_done = 1'b1;
            #1;
            chk(word_strobe == 1'b0, "R8 no strobe with completion", int'(word_strobe), 0);
            step;
            xfer_done = 1'b0;
            chk(busy == 1'b0, "R8 idle after completion", int'(busy), 0);
            for (int i = 0; i < 2 * t + 4; i++) begin
                chk(word_strobe == 1'b0, "R8 quiet after completion", int'(word_strobe), 0);
                step;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog R6 run did not end actual=%0d expected=%0d", 1, 0);
        finish_run;
    end

    initial begin
        int cur;
        step;
        step;
        chk(position == 5'd0, "R1 reset position", int'(position), 0);
        chk(index_flag == 1'b1, "R1 reset index_flag", int'(index_flag), 1);
        chk(word_strobe == 1'b0, "R1 reset word_strobe", int'(word_strobe), 0);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(addr_match == 1'b1, "R5 reset match at address 0", int'(addr_match), 1);
        rst_n = 1'b1;
        step;
        chk(position == 5'd1, "R1 time of 1 after reset", int'(position), 1);

        sweep(1, -1);
        sweep(2, -1);
        sweep(3, 10);

        iw_wr = 1'b1;
        iw_time = TW'(2);
        step;
        iw_wr = 1'b0;
        sched(0, 1'b0, 8, 2);
        sched(5, 1'b0, 10, 2);
        sched(31, 1'b0, 6, 2);
        cur = int'(position);
        sched(cur, 1'b0, 6, 2);
        cur = int'(position);
        sched((cur + 2) % W, 1'b0, 6, 2);
        sched(17, 1'b1, 0, 2);

        iw_wr = 1'b1;
        iw_time = TW'(1);
        step;
        iw_wr = 1'b0;
        sched(9, 1'b0, 12, 1);
        sched(28, 1'b1, 0, 1);
        finish_run;
    end

endmodule